// File: doc/BRIEF.md
# Interleaved Sampling Phase Sequencer

This block drives the digital control of a sixteen-way time-interleaved sampling front end from a single master clock. On every falling edge of that clock it releases exactly one channel from track into hold. It also opens the track window of the next channel in round-robin order, so that successive channels sample one master period apart. A channel's track window lasts one master cycle, directly ahead of its own sampling edge. For the other fifteen cycles of the interleave period it stays in hold. As a result, at most one sample capacitor loads the input at any moment.

Each per-channel track enable is formed by gating a rotating one-hot pointer with a run flag, so only the selected channel can switch. On the cycle after a channel enters hold, the block sends that channel's converter a one-cycle start strobe. An enable input pauses the rotation. Pausing parks every channel in hold without skipping anyone in the order, and the next enabled edge resumes at the channel that was due. All registers update on the falling master edge, and reset is synchronous and active low.

Top module: `isps_seq`

## Requirements
- R1: While `rst_n` is low at a falling edge, every `track_en` bit and every `conv_start` bit is 0 after that edge, and `chan_idx` is 0.
- R2: At no time is more than one bit of `track_en` high (bit k controls channel k).
- R3: While `en` is high and channel k is tracking, the next falling edge puts channel k into hold and starts tracking channel (k+1) mod 16. Channel 15 wraps to channel 0.
- R4: With `en` held high, each channel's `track_en` bit is high for exactly one cycle in every 16, so within any 32 consecutive cycles each channel tracks twice.
- R5: `conv_start[k]` is high for exactly one cycle, namely the cycle after the falling edge at which `track_en[k]` dropped. No strobe occurs otherwise.
- R6: The first falling edge after reset with `en` high makes channel 0 track, and no strobe is raised at that edge.
- R7: A falling edge with `en` low clears `track_en`. If a channel was tracking, that channel enters hold and gets its strobe, and `chan_idx` moves to the next channel. Further edges with `en` low change neither `track_en` nor `chan_idx` and raise no strobe.
- R8: When `en` returns high after a pause, the channel that tracks first is the one given by `chan_idx`, so no channel is skipped or repeated.
- R9: `chan_idx` is the binary number of the tracking channel while one is tracking. Otherwise it is the number of the channel that will track next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; state changes on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low parks all channels in hold |
| track_en | output | 16 | Per-channel track enable, bit k for channel k |
| conv_start | output | 16 | Per-channel one-cycle conversion start strobe |
| chan_idx | output | 4 | Number of the tracking (or next) channel |

## Verification
Two events land in the same cycle. On each edge of a steady run, one channel's conversion strobe rises in the same cycle that the next channel's track enable rises. The bench checks both vectors together at every sample, together with the one-hot limit. The sharper case comes when `en` is dropped while a channel is tracking. At that edge the hold transition must still issue a strobe while no new track window opens. Pauses are placed both mid-rotation and on channel 15, and the bench confirms the strobe, the empty track vector and the advanced index in that same sample.

// File: rtl/isps_pkg.sv
// Package: shared definitions for the interleaved sampling phase sequencer.
// Assumes: consumers size their vectors from their own NCH parameter.
package isps_pkg;

    // Default interleave factor of the front end.
    localparam int ISPS_NCH_DEFAULT = 16;

    // Run state: either one channel is in its track window or all hold.
    typedef enum logic {
        ST_HOLD_ALL = 1'b0,
        ST_TRACKING = 1'b1
    } run_state_t;

endpackage

// File: rtl/isps_ring.sv
// Module: isps_ring
// Rotating one-hot channel pointer. It advances one place per falling edge
// when asked and wraps from the top channel to channel 0.
// Assumes: NCH >= 2; reset is synchronous, active low.
module isps_ring #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           adv,
    output logic [NCH-1:0] ptr
);

    localparam logic [NCH-1:0] PTR_INIT = {{(NCH-1){1'b0}}, 1'b1};

    // Rotate the pointer one channel up on each advance request.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            ptr <= PTR_INIT;
        end else if (adv) begin
            ptr <= {ptr[NCH-2:0], ptr[NCH-1]};
        end
    end

endmodule

// File: rtl/isps_enc.sv
// Module: isps_enc
// Converts the one-hot channel pointer into a binary channel number.
// Assumes: the input has exactly one bit set (the ring guarantees it).
module isps_enc #(
    parameter int NCH  = 16,
    parameter int IDXW = $clog2(NCH)
) (
    input  logic [NCH-1:0]  onehot,
    output logic [IDXW-1:0] index
);

    // OR together the numbers of all set bits.
    always_comb begin
        index = '0;
        for (int k = 0; k < NCH; k++) begin
            if (onehot[k]) begin
                index = index | IDXW'(k);
            end
        end
    end

endmodule

// File: rtl/isps_gate.sv
// Module: isps_gate
// Per-channel output stage. It gates the pointer with the run flag to form
// the track enables, and it registers a conversion strobe for the channel
// that leaves track at the current edge.
// Assumes: ptr is one-hot; hold_ev is high on edges that end a track window.
module isps_gate #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ptr,
    input  logic           tracking,
    input  logic           hold_ev,
    output logic [NCH-1:0] track_en,
    output logic [NCH-1:0] conv_start
);

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        // Only the pointed-to channel may track, and only while running.
        assign track_en[k] = ptr[k] & tracking;

        // Strobe the converter of the channel entering hold at this edge.
        always_ff @(negedge clk) begin
            if (!rst_n) begin
                conv_start[k] <= 1'b0;
            end else begin
                conv_start[k] <= ptr[k] & hold_ev;
            end
        end
    end

endmodule

// File: rtl/isps_seq.sv
// Module: isps_seq (top)
// Sequences track/hold of a time-interleaved sampler. Each falling master
// edge ends the current track window (hold plus conversion strobe) and,
// while enabled, opens the next channel's window in round-robin order.
// Assumes: single master clock; all state on its falling edge; en is
// synchronous to that edge.
module isps_seq
    import isps_pkg::*;
#(
    parameter int NCH  = ISPS_NCH_DEFAULT,
    parameter int IDXW = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    output logic [NCH-1:0]  track_en,
    output logic [NCH-1:0]  conv_start,
    output logic [IDXW-1:0] chan_idx
);

    run_state_t     run_q;
    logic           hold_ev;
    logic           tracking;
    logic [NCH-1:0] ptr;

    // A tracking channel always enters hold at the next edge.
    assign tracking = (run_q == ST_TRACKING);
    assign hold_ev  = tracking;

    // Run flag: follow the enable, cleared by reset.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            run_q <= ST_HOLD_ALL;
        end else begin
            run_q <= en ? ST_TRACKING : ST_HOLD_ALL;
        end
    end

    isps_ring #(.NCH(NCH)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (hold_ev),
        .ptr   (ptr)
    );

    isps_gate #(.NCH(NCH)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr        (ptr),
        .tracking   (tracking),
        .hold_ev    (hold_ev),
        .track_en   (track_en),
        .conv_start (conv_start)
    );

    isps_enc #(.NCH(NCH), .IDXW(IDXW)) u_enc (
        .onehot (ptr),
        .index  (chan_idx)
    );

endmodule

// File: rtl/isps_chk.sv
// Module: isps_chk
// Checker for isps_seq, bound to every instance of it. Sampled on the
// falling master edge, the edge the design updates on.
// Assumes: NCH >= 2.
module isps_chk #(
    parameter int NCH  = 16,
    parameter int IDXW = $clog2(NCH)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic [NCH-1:0]  track_en,
    input logic [NCH-1:0]  conv_start,
    input logic [IDXW-1:0] chan_idx
);

    // R2: at most one channel tracks.
    p_single_track_r2: assert property (@(negedge clk) disable iff (!rst_n)
        $onehot0(track_en));

    // R3: an enabled edge moves the window to the next channel.
    p_rotate_r3: assert property (@(negedge clk) disable iff (!rst_n)
        (en && (|track_en)) |=>
            (track_en == {$past(track_en[NCH-2:0]), $past(track_en[NCH-1])}));

    // R4: no channel tracks for two cycles in a row.
    p_window_len_r4: assert property (@(negedge clk) disable iff (!rst_n)
        (|track_en) |=> ((track_en & $past(track_en)) == '0));

    // R5: a strobe follows exactly the channel whose window closed.
    p_strobe_r5: assert property (@(negedge clk) disable iff (!rst_n)
        1'b1 |=> (conv_start == ($past(track_en) & ~track_en)));

    // R5: strobes never overlap.
    p_strobe_single_r5: assert property (@(negedge clk) disable iff (!rst_n)
        $onehot0(conv_start));

    // R7: a disabled edge parks everything in hold.
    p_pause_hold_r7: assert property (@(negedge clk) disable iff (!rst_n)
        (!en) |=> (track_en == '0));

    // R7: an idle disabled edge keeps the index.
    p_pause_idx_r7: assert property (@(negedge clk) disable iff (!rst_n)
        (!en && (track_en == '0)) |=> $stable(chan_idx));

endmodule

bind isps_seq isps_chk #(.NCH(NCH), .IDXW(IDXW)) u_isps_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .track_en   (track_en),
    .conv_start (conv_start),
    .chan_idx   (chan_idx)
);

// File: tb/isps_seq_bench.sv
// Directed bench for isps_seq. Inputs are driven just after the rising
// edge, and outputs are sampled just after the rising edge, away from the
// falling edge on which the design updates.
module isps_seq_bench;

    localparam int NCH  = 16;
    localparam int IDXW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            en = 1'b0;
    logic [NCH-1:0]  track_en;
    logic [NCH-1:0]  conv_start;
    logic [IDXW-1:0] chan_idx;

    int n_chk  = 0;
    int n_fail = 0;

    // Expected state derived from the requirements.
    bit             m_trk  = 1'b0;
    int             m_idx  = 0;
    logic [NCH-1:0] m_conv = '0;

    always #4 clk = ~clk;

    isps_seq #(.NCH(NCH), .IDXW(IDXW)) u_isps_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .track_en   (track_en),
        .conv_start (conv_start),
        .chan_idx   (chan_idx)
    );

    function automatic logic [NCH-1:0] exp_track();
        return m_trk ? (NCH'(1) << m_idx) : '0;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "track_en", 32'(track_en), 32'(exp_track()));
        chk(tag, "conv_start", 32'(conv_start), 32'(m_conv));
        chk(tag, "chan_idx", 32'(chan_idx), 32'(m_idx));
        chk("R2", "track count", 32'($countones(track_en)), 32'(m_trk ? 1 : 0));
    endtask

    // One master cycle: apply inputs, advance the model at the falling edge, check.
    task automatic cycle(input logic rst_v, input logic en_v, input string tag);
        rst_n = rst_v;
        en    = en_v;
        @(negedge clk);
        if (!rst_v) begin
            m_trk = 1'b0; m_idx = 0; m_conv = '0;
        end else begin
            m_conv = m_trk ? (NCH'(1) << m_idx) : '0;
            if (m_trk) m_idx = (m_idx + 1) % NCH;
            m_trk = en_v;
        end
        @(posedge clk);
        #1;
        check_all(tag);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, "R1");
    endtask

    task automatic t_first();
        cycle(1'b1, 1'b1, "R6");
        chk("R6", "channel 0 tracks", 32'(track_en), 32'h1);
        chk("R6", "no strobe", 32'(conv_start), 32'h0);
    endtask

    task automatic t_rotate();
        int cnt [NCH];
        for (int k = 0; k < NCH; k++) cnt[k] = 0;
        for (int i = 0; i < 2 * NCH; i++) begin
            cycle(1'b1, 1'b1, "R3");
            chk("R9", "index of tracker", 32'(chan_idx), 32'(m_idx));
            chk("R5", "strobe of previous", 32'(conv_start),
                32'(NCH'(1) << ((m_idx + NCH - 1) % NCH)));
            for (int k = 0; k < NCH; k++) if (track_en[k]) cnt[k]++;
        end
        for (int k = 0; k < NCH; k++) chk("R4", "windows in 32", 32'(cnt[k]), 32'd2);
    endtask

    task automatic t_pause(input int stop_ch);
        int guard = 0;
        while (m_idx != stop_ch && guard < 2 * NCH) begin
            cycle(1'b1, 1'b1, "R3");
            guard++;
        end
        cycle(1'b1, 1'b0, "R7");
        chk("R7", "track cleared", 32'(track_en), 32'h0);
        chk("R7", "strobe of paused", 32'(conv_start), 32'(NCH'(1) << stop_ch));
        chk("R7", "index advanced", 32'(chan_idx), 32'((stop_ch + 1) % NCH));
        for (int i = 0; i < 3; i++) begin
            cycle(1'b1, 1'b0, "R7");
            chk("R7", "idle no strobe", 32'(conv_start), 32'h0);
        end
        cycle(1'b1, 1'b1, "R8");
        chk("R8", "resume channel", 32'(track_en), 32'(NCH'(1) << ((stop_ch + 1) % NCH)));
        for (int i = 0; i < 3; i++) cycle(1'b1, 1'b1, "R3");
    endtask

    task automatic t_reset_mid();
        cycle(1'b0, 1'b1, "R1");
        chk("R1", "index zero", 32'(chan_idx), 32'h0);
        t_first();
    endtask

    initial begin : watchdog
        #1600000;
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        @(posedge clk);
        #1;
        t_reset();
        t_first();
        t_rotate();
        t_pause(6);
        t_pause(15);
        t_reset_mid();
        for (int i = 0; i < 5; i++) cycle(1'b1, 1'b1, "R3");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule